// File: doc/BRIEF.md
# Power Mode Clock Controller

This block decides, cycle by cycle, which clock domains of a small microcontroller are allowed to toggle. Software selects a mode with a one-cycle request strobe and a 3-bit mode code. The block turns that choice into clock enables for four domains: CPU, general peripherals, LCD controller and real-time clock. It also drives enables for the main oscillator and the RC oscillator. The modes are full-speed run, idle, a divide-by-32 slow-down, and three power-down depths. The depths differ only in which domains keep their clock.

Each mode has its own set of wake-up sources that may end it. The wake-up inputs are the external interrupt 0 pin, the real-time clock interrupt and a generic interrupt. All three are level-sensitive, and each passes through a two-flop synchroniser clocked by the always-running reference clock. After a wake from any power-down depth, the oscillators are switched back on at once. The CPU and peripheral enables stay low for a settling window before they are released. An active-low reset returns everything to run mode.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset, `cur_mode` is 0 (run), all four domain enables and both oscillator enables are 1, and `slow_tick` is 0.
- R2: Mode code 1 (idle) drives `cpu_clk_en` to 0 and keeps the peripheral, LCD and RTC enables and both oscillator enables at 1.
- R3: Idle ends, returning to run with `cpu_clk_en` at 1 at once, when any of `ext_int0`, `rtc_int` or `irq` is high.
- R4: Mode code 2 (slow-down) keeps both oscillators on. The four domain enables equal `slow_tick`. `slow_tick` is first high in the 32nd cycle spent in slow-down, and then every 32 cycles.
- R5: Slow-down is left only by a request with code 0. Other codes and all wake-up inputs leave it unchanged.
- R6: Mode code 3 (power-down 1) drives all four domain enables and both oscillator enables to 0.
- R7: Mode code 4 (power-down 2) leaves only the LCD and RTC enables at 1. The CPU, peripheral and both oscillator enables are 0.
- R8: Mode code 5 (power-down 3) leaves only the RTC enable at 1.
- R9: Power-down 1 is ended only by `ext_int0`. `rtc_int` and `irq` do not end it.
- R10: Power-down 2 and 3 are ended by `ext_int0` or `rtc_int`. `irq` does not end them.
- R11: On a wake from any power-down depth, the mode becomes run and both oscillator enables return to 1. The LCD and RTC enables are 1. `cpu_clk_en` and `per_clk_en` stay 0 for 16 cycles, including the wake cycle, and rise in the 17th. Requests made in this window are ignored.
- R12: A request is acted on only in settled run mode or in slow-down. Codes 6 and 7 are ignored. Requests made in idle or power-down are dropped.
- R13: A wake-up input that goes high changes the mode at the third rising clock edge after it goes high. It has no effect on the mode at the first two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code (0 run, 1 idle, 2 slow, 3/4/5 power-down 1/2/3) |
| ext_int0 | input | 1 | External interrupt 0 pin, level wake-up |
| rtc_int | input | 1 | Real-time clock interrupt, level wake-up |
| irq | input | 1 | Generic interrupt, level wake-up |
| cpu_clk_en | output | 1 | CPU domain clock enable |
| per_clk_en | output | 1 | General peripheral domain clock enable |
| lcd_clk_en | output | 1 | LCD domain clock enable |
| rtc_clk_en | output | 1 | RTC domain clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| slow_tick | output | 1 | Divide-by-32 enable pulse in slow-down mode |
| cur_mode | output | 3 | Current mode code |

## Verification
A synchronised wake-up and a software mode request can land on the same clock edge. The bench provokes this in idle: it raises `ext_int0`, waits the two synchroniser edges, and then strobes a power-down request so that both arrive at the third edge. The result is judged correct when the mode returns to run and stays there the following cycle, showing that the wake took effect and the request was dropped. A second overlap is a request that arrives inside the post-wake settling window. It must leave the mode at run and must not shorten or stretch the 16-cycle hold on the CPU and peripheral enables.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_RUN  = 3'd0,
        MODE_IDLE = 3'd1,
        MODE_SLOW = 3'd2,
        MODE_PD1  = 3'd3,
        MODE_PD2  = 3'd4,
        MODE_PD3  = 3'd5
    } pmc_mode_e;

    localparam int unsigned PMC_MODE_MAX = 5;

    // one bit per gated target
    typedef struct packed {
        logic cpu;
        logic per;
        logic lcd;
        logic rtc;
        logic main_osc;
        logic rc_osc;
    } pmc_gate_t;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_slow_div.sv
module pmc_slow_div #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run_en && (cnt_q == LAST);

endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] INIT = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = INIT;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned SLOW_DIV    = 32,
    parameter int unsigned SETTLE_CYC  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_mode,
    input  logic       ext_int0,
    input  logic       rtc_int,
    input  logic       irq,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       lcd_clk_en,
    output logic       rtc_clk_en,
    output logic       main_osc_en,
    output logic       rc_osc_en,
    output logic       slow_tick,
    output logic [2:0] cur_mode
);

    localparam int unsigned NSRC = 3;

    typedef struct packed {
        pmc_mode_e mode;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        wake_pd;
    logic        settle_busy;
    logic        tick;
    logic        ext_s, rtc_s, irq_s;
    logic [NSRC-1:0] src_sync;
    logic        req_ok;
    pmc_gate_t   gate;

    pmc_sync #(
        .WIDTH (NSRC),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({irq, rtc_int, ext_int0}),
        .dout (src_sync)
    );

    assign ext_s = src_sync[0];
    assign rtc_s = src_sync[1];
    assign irq_s = src_sync[2];

    pmc_slow_div #(
        .DIV(SLOW_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run_en(st_q.mode == MODE_SLOW),
        .tick  (tick)
    );

    pmc_settle #(
        .CYCLES(SETTLE_CYC)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wake_pd),
        .busy (settle_busy)
    );

    assign req_ok = req_valid && (int'(req_mode) <= PMC_MODE_MAX);

    // next-state
    always_comb begin
        st_d    = st_q;
        wake_pd = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (req_ok && !settle_busy) begin
                    st_d.mode = pmc_mode_e'(req_mode);
                end
            end
            MODE_SLOW: begin
                if (req_ok && (req_mode == 3'd0)) begin
                    st_d.mode = MODE_RUN;
                end
            end
            MODE_IDLE: begin
                if (ext_s || rtc_s || irq_s) begin
                    st_d.mode = MODE_RUN;
                end
            end
            MODE_PD1: begin
                if (ext_s) begin
                    st_d.mode = MODE_RUN;
                    wake_pd   = 1'b1;
                end
            end
            MODE_PD2, MODE_PD3: begin
                if (ext_s || rtc_s) begin
                    st_d.mode = MODE_RUN;
                    wake_pd   = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // gate map
    always_comb begin
        gate = '1;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (settle_busy) begin
                    gate.cpu = 1'b0;
                    gate.per = 1'b0;
                end
            end
            MODE_IDLE: gate.cpu = 1'b0;
            MODE_SLOW: begin
                gate.cpu = tick;
                gate.per = tick;
                gate.lcd = tick;
                gate.rtc = tick;
            end
            MODE_PD1: gate = '0;
            MODE_PD2: begin
                gate     = '0;
                gate.lcd = 1'b1;
                gate.rtc = 1'b1;
            end
            MODE_PD3: begin
                gate     = '0;
                gate.rtc = 1'b1;
            end
            default: gate = '1;
        endcase
    end

    assign cpu_clk_en  = gate.cpu;
    assign per_clk_en  = gate.per;
    assign lcd_clk_en  = gate.lcd;
    assign rtc_clk_en  = gate.rtc;
    assign main_osc_en = gate.main_osc;
    assign rc_osc_en   = gate.rc_osc;
    assign slow_tick   = tick;
    assign cur_mode    = st_q.mode;

endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_mode,
    input logic       ext_s,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       lcd_clk_en,
    input logic       rtc_clk_en,
    input logic       main_osc_en,
    input logic       rc_osc_en,
    input logic       slow_tick,
    input logic [2:0] cur_mode
);

    p_idle_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd1) |-> (!cpu_clk_en && per_clk_en && lcd_clk_en && rtc_clk_en));

    p_tick_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> (cur_mode == 3'd2));

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> !slow_tick);

    p_slow_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd2) |-> (main_osc_en && rc_osc_en && (cpu_clk_en == per_clk_en)));

    p_pd1_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd3) |-> !(cpu_clk_en || per_clk_en || lcd_clk_en || rtc_clk_en
                                 || main_osc_en || rc_osc_en));

    p_pd2_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd4) |-> (lcd_clk_en && rtc_clk_en && !cpu_clk_en && !per_clk_en
                                && !main_osc_en && !rc_osc_en));

    p_pd3_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd5) |-> (rtc_clk_en && !lcd_clk_en && !cpu_clk_en
                                && !main_osc_en && !rc_osc_en));

    p_pd1_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd3 && !ext_s) |=> (cur_mode == 3'd3));

    p_settle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_mode) >= 3'd3 && cur_mode == 3'd0)
        |-> (!cpu_clk_en && !per_clk_en && main_osc_en && rc_osc_en));

    p_bad_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && cpu_clk_en && req_valid && req_mode >= 3'd6)
        |=> (cur_mode == 3'd0));

endmodule

bind pmc_ctrl pmc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .ext_s      (ext_s),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .lcd_clk_en (lcd_clk_en),
    .rtc_clk_en (rtc_clk_en),
    .main_osc_en(main_osc_en),
    .rc_osc_en  (rc_osc_en),
    .slow_tick  (slow_tick),
    .cur_mode   (cur_mode)
);

// File: tb/pmc_ctrl_tb_top.sv
module pmc_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic       ext_int0 = 1'b0;
    logic       rtc_int = 1'b0;
    logic       irq = 1'b0;
    logic       cpu_clk_en, per_clk_en, lcd_clk_en, rtc_clk_en;
    logic       main_osc_en, rc_osc_en, slow_tick;
    logic [2:0] cur_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pmc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .ext_int0(ext_int0), .rtc_int(rtc_int), .irq(irq),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .lcd_clk_en(lcd_clk_en),
        .rtc_clk_en(rtc_clk_en), .main_osc_en(main_osc_en), .rc_osc_en(rc_osc_en),
        .slow_tick(slow_tick), .cur_mode(cur_mode)
    );

    // {cpu, per, lcd, rtc, main, rc}
    function automatic logic [5:0] en_vec();
        return {cpu_clk_en, per_clk_en, lcd_clk_en, rtc_clk_en, main_osc_en, rc_osc_en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_mode = '0;
        ext_int0 = 1'b0; rtc_int = 1'b0; irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic request(input logic [2:0] code);
        req_valid = 1'b1; req_mode = code;
        @(negedge clk);
        req_valid = 1'b0; req_mode = '0;
    endtask

    task automatic wait_run();
        for (int k = 0; k < 8; k++) begin
            if (cur_mode == 3'd0) break;
            @(negedge clk);
        end
    endtask

    function automatic string vec_tag(input logic [2:0] c);
        case (c)
            3'd0: return "R1 run request";
            3'd1: return "R2 idle entry";
            3'd2: return "R4 slow entry";
            3'd3: return "R6 pd1 entry";
            3'd4: return "R7 pd2 entry";
            3'd5: return "R8 pd3 entry";
            default: return "R12 reserved code";
        endcase
    endfunction

    // {code[2:0], exp_mode[2:0], exp_en[5:0]}; slow sampled in its first (non-tick) cycle
    localparam int NVEC = 8;
    localparam logic [NVEC-1:0][11:0] VEC = {
        {3'd0, 3'd0, 6'b111111},
        {3'd1, 3'd1, 6'b011111},
        {3'd2, 3'd2, 6'b000011},
        {3'd3, 3'd3, 6'b000000},
        {3'd4, 3'd4, 6'b001100},
        {3'd5, 3'd5, 6'b000100},
        {3'd6, 3'd0, 6'b111111},
        {3'd7, 3'd0, 6'b111111}
    };

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 reset mode", cur_mode, 0);
        check("R1 reset enables", en_vec(), 6'b111111);
        check("R1 reset tick", slow_tick, 0);

        // table walk: entry from run into each code
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[NVEC-1-i];
            do_reset();
            request(v[11:9]);
            check(vec_tag(v[11:9]), cur_mode, v[8:6]);
            check(vec_tag(v[11:9]), en_vec(), v[5:0]);
        end

        // R3 / R13: idle wake by ext, latency of three edges
        do_reset();
        request(3'd1);
        ext_int0 = 1'b1;
        repeat (2) @(negedge clk);
        check("R13 no early wake", cur_mode, 1);
        @(negedge clk);
        check("R13 wake at third edge", cur_mode, 0);
        check("R3 idle exit no settle", cpu_clk_en, 1);
        ext_int0 = 1'b0;

        // R3 idle wake by irq and rtc
        do_reset();
        request(3'd1);
        irq = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 idle exit by irq", cur_mode, 0);
        irq = 1'b0;
        do_reset();
        request(3'd1);
        rtc_int = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 idle exit by rtc", cur_mode, 0);
        rtc_int = 1'b0;

        // R12 concurrency: wake and request on the same edge in idle
        do_reset();
        request(3'd1);
        ext_int0 = 1'b1;
        repeat (2) @(negedge clk);
        request(3'd3);
        check("R12 wake wins over request", cur_mode, 0);
        ext_int0 = 1'b0;
        @(negedge clk);
        check("R12 dropped request stays dropped", cur_mode, 0);

        // R12 request in idle ignored
        do_reset();
        request(3'd1);
        request(3'd0);
        check("R12 request in idle ignored", cur_mode, 1);

        // R4 slow tick timing
        do_reset();
        request(3'd2);
        repeat (30) @(negedge clk);
        check("R4 no tick at cycle 31", slow_tick, 0);
        @(negedge clk);
        check("R4 tick at cycle 32", slow_tick, 1);
        check("R4 enables on tick", en_vec(), 6'b111111);
        @(negedge clk);
        check("R4 tick one cycle", slow_tick, 0);
        repeat (31) @(negedge clk);
        check("R4 next tick after 32", slow_tick, 1);

        // R5 slow ignores wake inputs and non-zero codes
        ext_int0 = 1'b1; rtc_int = 1'b1; irq = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 wake ignored in slow", cur_mode, 2);
        ext_int0 = 1'b0; rtc_int = 1'b0; irq = 1'b0;
        repeat (3) @(negedge clk);
        request(3'd3);
        check("R5 code 3 ignored in slow", cur_mode, 2);
        request(3'd0);
        check("R5 code 0 leaves slow", cur_mode, 0);

        // R9 pd1 ignores rtc and irq, wakes on ext
        do_reset();
        request(3'd3);
        rtc_int = 1'b1; irq = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 rtc/irq ignored in pd1", cur_mode, 3);
        check("R9 pd1 enables stay off", en_vec(), 6'b000000);
        rtc_int = 1'b0; irq = 1'b0;
        ext_int0 = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 ext wakes pd1", cur_mode, 0);
        ext_int0 = 1'b0;

        // R10 pd3 ignores irq, wakes on ext
        do_reset();
        request(3'd5);
        irq = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 irq ignored in pd3", cur_mode, 5);
        irq = 1'b0;
        ext_int0 = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 ext wakes pd3", cur_mode, 0);
        ext_int0 = 1'b0;

        // R10 / R11: pd2 wake by rtc, settle window, request in window
        do_reset();
        request(3'd4);
        rtc_int = 1'b1;
        wait_run();
        check("R10 rtc wakes pd2", cur_mode, 0);
        check("R11 settle enables", en_vec(), 6'b001111);
        rtc_int = 1'b0;
        request(3'd1);
        check("R11 request in settle ignored", cur_mode, 0);
        repeat (14) @(negedge clk);
        check("R11 cpu still held at 16th cycle", cpu_clk_en, 0);
        @(negedge clk);
        check("R11 released in 17th cycle", en_vec(), 6'b111111);
        check("R11 mode after settle", cur_mode, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule